// File: doc/BRIEF.md
# Adapter Reset and Startup Sequencer

This block brings the glue logic of a network adapter out of reset and programs its startup registers. It drives three active-low reset lines, one each for the adapter core, the host interface and the receive/transmit FIFO, and holds two configuration values: an interrupt-control byte and a FIFO threshold byte. Three one-cycle requests start its work. A basic-enable request lifts only the core reset and then waits a fixed time. A close request pulls every reset low at once. An open request runs the full bring-up.

The full bring-up first lifts the core reset and then asserts all three resets together. It keeps them asserted for a timed interval and releases them one per clock, core first, then host interface, then FIFO. Only after the last release does it write the interrupt-control value and then the FIFO threshold. Every timed interval is a count of time units, and each unit is a parameterised number of clock cycles. One down-counter is reloaded for each timed step.

While a sequence is running the block raises `busy`. It ignores every request until it is back in idle. A one-cycle `done` pulse marks the end of each accepted request.

Top module: `adapter_init_seq`

## Requirements
- R1: While `rst_n` is low, `core_rst_n`, `host_rst_n` and `fifo_rst_n` are all low, `irq_ctrl` and `fifo_thresh` are zero, and `busy` and `done` are low.
- R2: A basic-enable request accepted in idle drives `core_rst_n` high at the next clock edge and leaves `host_rst_n` and `fifo_rst_n` unchanged. `busy` then stays high for ENABLE_UNITS*UNIT_CYCLES cycles, and `done` rises as `busy` falls.
- R3: An open request accepted in idle drives `core_rst_n` high one edge after acceptance. At the following edge it drives all three reset lines low together.
- R4: During an open sequence, all three reset lines stay low together for exactly HOLD_UNITS*UNIT_CYCLES+1 cycles before any of them is released.
- R5: After the hold, the resets are released one per clock cycle in the order core, host interface, FIFO.
- R6: One cycle after the FIFO reset is released, `irq_ctrl` takes a value with bit SYS_IRQ_BIT (system interrupt enable, default bit 0) and bit BUS_ERR_BIT (bus-error interrupt enable, default bit 7) set and every other bit clear. With the defaults this is 8'h81.
- R7: One cycle after the `irq_ctrl` write, `fifo_thresh` takes the value FIFO_THRESH (default decimal 30), and `done` pulses in that same cycle. The whole open sequence keeps `busy` high for HOLD_UNITS*UNIT_CYCLES+7 cycles.
- R8: A close request accepted in idle drives all three reset lines low at the next edge and pulses `done` there. `busy` never rises, and `irq_ctrl` and `fifo_thresh` keep their values.
- R9: Requests that arrive while `busy` is high are ignored: they neither change the reset lines nor start a further sequence once the current one completes.
- R10: When several requests arrive together in idle, close takes precedence over open, and open takes precedence over basic enable.
- R11: `done` is high for exactly one cycle at the end of each accepted open or basic-enable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| open_req | input | 1 | Start the full bring-up sequence |
| close_req | input | 1 | Assert every adapter reset at once |
| enable_req | input | 1 | Lift only the core reset, then wait |
| core_rst_n | output | 1 | Active-low reset to the adapter core |
| host_rst_n | output | 1 | Active-low reset to the host-interface logic |
| fifo_rst_n | output | 1 | Active-low reset to the FIFO logic |
| irq_ctrl | output | REG_W | Interrupt-control register value |
| fifo_thresh | output | REG_W | FIFO threshold register value |
| busy | output | 1 | A sequence is in progress; requests are ignored |
| done | output | 1 | One-cycle pulse when an accepted request completes |

## Verification
The hardest case to reach from the ports is a request that lands in the middle of a long timed hold. The bench must show that the request has no effect at all, neither at once nor as a leftover start after completion. To get there, the bench starts an open sequence, counts falling edges into the hold window, and pulses close and basic enable together there. It then follows the outputs past `done`, checking that the lines end fully released and that `busy` stays low afterwards. Cycle-exact ordering is checked by timing the first change of every output from a known reset state. Arbitration is checked by raising all requests in the same cycle.

// File: rtl/adinit_pkg.sv
package adinit_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EN_WAIT,
    ST_OP_CORE,
    ST_OP_ASSERT,
    ST_OP_HOLD,
    ST_REL_CORE,
    ST_REL_HOST,
    ST_REL_FIFO,
    ST_WR_IRQ,
    ST_WR_THR
  } seq_state_e;

  typedef enum logic [2:0] {
    RC_KEEP,
    RC_UP_CORE,
    RC_UP_HOST,
    RC_UP_FIFO,
    RC_ALL_DOWN
  } rst_cmd_e;

  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned LINE_CORE = 0;
  localparam int unsigned LINE_HOST = 1;
  localparam int unsigned LINE_FIFO = 2;

endpackage

// File: rtl/adinit_wait_timer.sv
module adinit_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // R4: a running count only ever moves down by one
  a_r4_count_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adinit_rst_bank.sv
module adinit_rst_bank
  import adinit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  rst_cmd_e             cmd,
  output logic [NUM_LINES-1:0] line_n
);

  logic [NUM_LINES-1:0] line_q;

  for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
    rst_cmd_e up_code;
    logic     line_d;
    logic     line_en;

    always_comb begin
      case (gi)
        LINE_CORE: up_code = RC_UP_CORE;
        LINE_HOST: up_code = RC_UP_HOST;
        default:   up_code = RC_UP_FIFO;
      endcase
    end

    always_comb begin
      line_en = 1'b0;
      line_d  = line_q[gi];
      if (cmd == RC_ALL_DOWN) begin
        line_en = 1'b1;
        line_d  = 1'b0;
      end else if (cmd == up_code) begin
        line_en = 1'b1;
        line_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[gi] <= 1'b0;
      end else if (line_en) begin
        line_q[gi] <= line_d;
      end
    end
  end

  assign line_n = line_q;

endmodule

// File: rtl/adinit_cfg_regs.sv
module adinit_cfg_regs #(
  parameter int unsigned      REG_W   = 8,
  parameter logic [REG_W-1:0] IRQ_VAL = '0,
  parameter logic [REG_W-1:0] THR_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_irq,
  input  logic             we_thr,
  output logic [REG_W-1:0] irq_q,
  output logic [REG_W-1:0] thr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else if (we_irq) begin
      irq_q <= IRQ_VAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (we_thr) begin
      thr_q <= THR_VAL;
    end
  end

  // R7: the threshold changes only once interrupt control is programmed
  a_r7_thresh_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(thr_q) |-> (irq_q == IRQ_VAL));

endmodule

// File: rtl/adapter_init_seq.sv
module adapter_init_seq
  import adinit_pkg::*;
#(
  parameter int unsigned UNIT_CYCLES  = 2,
  parameter int unsigned HOLD_UNITS   = 100,
  parameter int unsigned ENABLE_UNITS = 100,
  parameter int unsigned REG_W        = 8,
  parameter int unsigned SYS_IRQ_BIT  = 0,
  parameter int unsigned BUS_ERR_BIT  = 7,
  parameter int unsigned FIFO_THRESH  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             enable_req,
  output logic             core_rst_n,
  output logic             host_rst_n,
  output logic             fifo_rst_n,
  output logic [REG_W-1:0] irq_ctrl,
  output logic [REG_W-1:0] fifo_thresh,
  output logic             busy,
  output logic             done
);

  localparam int unsigned HOLD_CYC = HOLD_UNITS * UNIT_CYCLES;
  localparam int unsigned EN_CYC   = ENABLE_UNITS * UNIT_CYCLES;
  localparam int unsigned MAX_CYC  = (HOLD_CYC > EN_CYC) ? HOLD_CYC : EN_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [REG_W-1:0] IRQ_VAL = REG_W'(1 << SYS_IRQ_BIT) | REG_W'(1 << BUS_ERR_BIT);
  localparam logic [REG_W-1:0] THR_VAL = REG_W'(FIFO_THRESH);

  seq_state_e           state_q, state_d;
  rst_cmd_e             rcmd;
  logic                 t_load, t_run, t_expired;
  logic [CNT_W-1:0]     t_val;
  logic                 we_irq, we_thr;
  logic                 done_q, done_d;
  logic [NUM_LINES-1:0] lines;

  always_comb begin
    state_d = state_q;
    rcmd    = RC_KEEP;
    t_load  = 1'b0;
    t_val   = '0;
    t_run   = 1'b0;
    we_irq  = 1'b0;
    we_thr  = 1'b0;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (close_req) begin
          rcmd   = RC_ALL_DOWN;
          done_d = 1'b1;
        end else if (open_req) begin
          state_d = ST_OP_CORE;
        end else if (enable_req) begin
          rcmd    = RC_UP_CORE;
          t_load  = 1'b1;
          t_val   = CNT_W'(EN_CYC - 1);
          state_d = ST_EN_WAIT;
        end
      end
      ST_EN_WAIT: begin
        t_run = 1'b1;
        if (t_expired) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_OP_CORE: begin
        rcmd    = RC_UP_CORE;
        state_d = ST_OP_ASSERT;
      end
      ST_OP_ASSERT: begin
        rcmd    = RC_ALL_DOWN;
        t_load  = 1'b1;
        t_val   = CNT_W'(HOLD_CYC - 1);
        state_d = ST_OP_HOLD;
      end
      ST_OP_HOLD: begin
        t_run = 1'b1;
        if (t_expired) state_d = ST_REL_CORE;
      end
      ST_REL_CORE: begin
        rcmd    = RC_UP_CORE;
        state_d = ST_REL_HOST;
      end
      ST_REL_HOST: begin
        rcmd    = RC_UP_HOST;
        state_d = ST_REL_FIFO;
      end
      ST_REL_FIFO: begin
        rcmd    = RC_UP_FIFO;
        state_d = ST_WR_IRQ;
      end
      ST_WR_IRQ: begin
        we_irq  = 1'b1;
        state_d = ST_WR_THR;
      end
      ST_WR_THR: begin
        we_thr  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  adinit_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .run      (t_run),
    .expired  (t_expired)
  );

  adinit_rst_bank u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (rcmd),
    .line_n (lines)
  );

  adinit_cfg_regs #(.REG_W(REG_W), .IRQ_VAL(IRQ_VAL), .THR_VAL(THR_VAL)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_irq (we_irq),
    .we_thr (we_thr),
    .irq_q  (irq_ctrl),
    .thr_q  (fifo_thresh)
  );

  assign core_rst_n = lines[LINE_CORE];
  assign host_rst_n = lines[LINE_HOST];
  assign fifo_rst_n = lines[LINE_FIFO];
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;

  // R4: every reset stays asserted while the hold interval runs
  a_r4_hold_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OP_HOLD) |-> (lines == '0));

  // R5: the host interface is released only after the core
  a_r5_host_after_core: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_n) |-> (core_rst_n && $past(core_rst_n)));

  // R5: the FIFO is released only after the host interface
  a_r5_fifo_after_host: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_rst_n) |-> (host_rst_n && $past(host_rst_n)));

  // R6: interrupt control changes only with every reset released
  a_r6_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(irq_ctrl) |-> (core_rst_n && host_rst_n && fifo_rst_n));

  // R9: completion is reported only on the return to idle
  a_r9_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/sim_adapter_init_seq.sv
module sim_adapter_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 2;
  localparam int HOLD_U     = 100;
  localparam int EN_U       = 40;
  localparam int HOLD_N     = HOLD_U * UNIT;
  localparam int EN_N       = EN_U * UNIT;
  localparam int OPEN_BUSY  = HOLD_N + 7;
  localparam logic [7:0] EXP_IRQ = 8'h81;
  localparam logic [7:0] EXP_THR = 8'd30;

  // vector: op[22:21] (0 enable, 1 open, 2 close), lines[20:18] {fifo,host,core}, busy[15:0]
  localparam logic [22:0] VECS [0:7] = '{
    {2'd2, 3'b000, 2'b00, 16'd0},
    {2'd0, 3'b001, 2'b00, 16'(EN_N)},
    {2'd0, 3'b001, 2'b00, 16'(EN_N)},
    {2'd1, 3'b111, 2'b00, 16'(OPEN_BUSY)},
    {2'd0, 3'b111, 2'b00, 16'(EN_N)},
    {2'd2, 3'b000, 2'b00, 16'd0},
    {2'd1, 3'b111, 2'b00, 16'(OPEN_BUSY)},
    {2'd2, 3'b000, 2'b00, 16'd0}
  };

  logic clk, rst_n, open_req, close_req, enable_req;
  logic core_rst_n, host_rst_n, fifo_rst_n, busy, done;
  logic [7:0] irq_ctrl, fifo_thresh;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  adapter_init_seq #(
    .UNIT_CYCLES(UNIT), .HOLD_UNITS(HOLD_U), .ENABLE_UNITS(EN_U),
    .REG_W(8), .SYS_IRQ_BIT(0), .BUS_ERR_BIT(7), .FIFO_THRESH(30)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .close_req(close_req),
    .enable_req(enable_req), .core_rst_n(core_rst_n), .host_rst_n(host_rst_n),
    .fifo_rst_n(fifo_rst_n), .irq_ctrl(irq_ctrl), .fifo_thresh(fifo_thresh),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [2:0] lines_now();
    return {fifo_rst_n, host_rst_n, core_rst_n};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit c, input bit o, input bit e, output int busy_n, output bit seen);
    @(negedge clk);
    close_req = c; open_req = o; enable_req = e;
    @(negedge clk);
    close_req = 0; open_req = 0; enable_req = 0;
    busy_n = 0; seen = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin seen = 1; break; end
      if (busy) busy_n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int bn;
    bit sn;
    int core_up1, core_up2, host_up, fifo_up, irq_k, thr_k, done_k, low_run, done_cnt;
    logic [7:0] irq_seen, thr_seen;

    rst_n = 0; open_req = 0; close_req = 0; enable_req = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(lines_now() == 3'b000, "R1 lines in reset", lines_now(), 0);
    check(irq_ctrl == 0 && fifo_thresh == 0, "R1 cfg in reset", {irq_ctrl, fifo_thresh}, 0);
    check(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
    rst_n = 1;

    // R3 R4 R5 R6 R7 R11: cycle timing of a full open from reset
    @(negedge clk); open_req = 1;
    @(negedge clk); open_req = 0;
    core_up1 = -1; core_up2 = -1; host_up = -1; fifo_up = -1;
    irq_k = -1; thr_k = -1; done_k = -1; low_run = 0; done_cnt = 0;
    irq_seen = 0; thr_seen = 0;
    for (int k = 0; k < HOLD_N + 14; k++) begin
      if (core_rst_n && core_up1 < 0) core_up1 = k;
      else if (core_rst_n && core_up1 >= 0 && core_up2 < 0 && k > core_up1 + 1) core_up2 = k;
      if (core_up1 >= 0 && lines_now() == 3'b000) low_run++;
      if (host_rst_n && host_up < 0) host_up = k;
      if (fifo_rst_n && fifo_up < 0) fifo_up = k;
      if (irq_ctrl != 0 && irq_k < 0) begin irq_k = k; irq_seen = irq_ctrl; end
      if (fifo_thresh != 0 && thr_k < 0) begin thr_k = k; thr_seen = fifo_thresh; end
      if (done) begin done_cnt++; if (done_k < 0) done_k = k; end
      @(negedge clk);
    end
    check(core_up1 == 1, "R3 core lifted first", core_up1, 1);
    check(low_run == HOLD_N + 1, "R4 all-low duration", low_run, HOLD_N + 1);
    check(core_up2 == HOLD_N + 3, "R5 core release cycle", core_up2, HOLD_N + 3);
    check(host_up == core_up2 + 1, "R5 host after core", host_up, core_up2 + 1);
    check(fifo_up == host_up + 1, "R5 fifo after host", fifo_up, host_up + 1);
    check(irq_k == fifo_up + 1, "R6 irq write cycle", irq_k, fifo_up + 1);
    check(irq_seen == EXP_IRQ, "R6 irq value", irq_seen, EXP_IRQ);
    check(thr_k == irq_k + 1, "R7 thresh write cycle", thr_k, irq_k + 1);
    check(thr_seen == EXP_THR, "R7 thresh value", thr_seen, EXP_THR);
    check(done_k == thr_k, "R7 done with thresh", done_k, thr_k);
    check(done_cnt == 1, "R11 done single pulse", done_cnt, 1);

    // R2 R7 R8 R11: table of requests
    for (int v = 0; v < 8; v++) begin
      run_op(VECS[v][22:21] == 2, VECS[v][22:21] == 1, VECS[v][22:21] == 0, bn, sn);
      check(sn, $sformatf("R11 done seen vec%0d", v), sn, 1);
      check(lines_now() == VECS[v][20:18], $sformatf("R2/R8 lines vec%0d", v), lines_now(), VECS[v][20:18]);
      check(bn == int'(VECS[v][15:0]), $sformatf("R2/R7/R8 busy length vec%0d", v), bn, VECS[v][15:0]);
      check(irq_ctrl == EXP_IRQ && fifo_thresh == EXP_THR, $sformatf("R8 cfg kept vec%0d", v),
            {irq_ctrl, fifo_thresh}, {EXP_IRQ, EXP_THR});
      @(negedge clk);
      check(!done, $sformatf("R11 done drops vec%0d", v), done, 0);
    end

    // R9: close and enable during the hold are ignored
    @(negedge clk); open_req = 1;
    @(negedge clk); open_req = 0;
    repeat (20) @(negedge clk);
    close_req = 1; enable_req = 1;
    @(negedge clk); close_req = 0; enable_req = 0;
    check(lines_now() == 3'b000 && busy, "R9 hold unaffected", {busy, lines_now()}, 4'b1000);
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    check(lines_now() == 3'b111, "R9 lines after ignored close", lines_now(), 3'b111);
    repeat (2) @(negedge clk);
    check(!busy && lines_now() == 3'b111, "R9 no leftover start", {busy, lines_now()}, 4'b0111);

    // R10: arbitration
    run_op(1, 1, 1, bn, sn);
    check(bn == 0 && lines_now() == 3'b000, "R10 close wins", lines_now(), 0);
    run_op(0, 1, 1, bn, sn);
    check(bn == OPEN_BUSY, "R10 open beats enable", bn, OPEN_BUSY);
    check(lines_now() == 3'b111, "R10 open result", lines_now(), 3'b111);

    // R1: reset in mid-sequence
    @(negedge clk); open_req = 1;
    @(negedge clk); open_req = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check(lines_now() == 3'b000 && irq_ctrl == 0 && fifo_thresh == 0 && !busy && !done,
          "R1 mid-sequence reset", {busy, lines_now()}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!busy, "R1 idle after reset", busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule